// File: doc/BRIEF.md
# Three-Channel Timer Register Front End

This block is the byte-wide host interface of a three-channel interval timer. It sits between an 8-bit register bus and three counter channels. The counting itself happens in the channels. Address 3 takes control words and read-back commands. Addresses 0 to 2 each reach one channel's 16-bit count through a per-channel byte sequencer. The sequencer can move the low byte only, the high byte only, or both bytes, low byte first.

On the write side, the block gathers the bytes of a new initial count. When the count is complete it pulses a load strobe to the target channel together with the 16-bit value. On the read side, it returns the channel's live count or a frozen copy taken by a latch command. It can also return a status byte that holds the channel's output level and settings. One read-back command can freeze the count, the status or both for any set of channels. A pending status is always returned before a pending count.

Writes and reads are single-cycle strobes. Read data is combinational and valid in the same cycle as the read strobe. State changes take effect at the following clock edge.

Top module: `tmr_portfront`

## Requirements
- R1: Only addr[1:0] is decoded, and the upper address bits are ignored. A read at register 3 returns 8'h00.
- R2: A control word at register 3 holds the channel in bits 7:6 (values 0 to 2), the access mode in bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high), the operating mode in bits 3:1 and the BCD flag in bit 0. After reset, every channel is in low-byte-only access, mode 0, BCD 0.
- R3: A control word whose access field is 0 copies the channel's live count into its count latch. The channel's access mode, operating mode and BCD flag stay unchanged.
- R4: A control word with a non-zero access field returns both the write and the read sequencer of that channel to the low byte.
- R5: In low-then-high access, the first data byte is held. Only the second byte loads the count {second, first}. The next byte is taken as a low byte again.
- R6: Low-byte-only access loads {8'h00, byte}. High-byte-only access loads {byte, 8'h00}.
- R7: A control word with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 latches the count and bit 4 = 0 latches the status, for every selected channel in the same cycle.
- R8: The status byte is {output level, 1'b0, access mode, operating mode, BCD}, in bits 7, 6, 5:4, 3:1 and 0.
- R9: A count latch or a status latch that has not yet been read is not overwritten by a later latch command.
- R10: A read returns a pending status first and clears it. Otherwise it returns a pending latched count (in low-then-high access, low byte then high byte) and releases it. Otherwise it returns the live count.
- R11: A live read returns the low byte in low-byte-only access and the high byte in high-byte-only access. In low-then-high access, successive reads alternate between low and high, starting with low.
- R12: load_stb of the addressed channel pulses for one cycle in the cycle after the write that completes a count, with load_val holding the count. Control writes and reads produce no load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Register address; only bits 1:0 are decoded |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of rd_en |
| live_cnt | input | 48 | Live 16-bit counts of channels 0, 1, 2 (channel i at bits 16i+15:16i) |
| ch_out | input | 3 | Output levels of the three channels |
| load_stb | output | 3 | Per-channel pulse to load a new initial count |
| load_val | output | 48 | Per-channel initial count (channel i at bits 16i+15:16i) |
| ch_mode | output | 9 | Per-channel operating mode (channel i at bits 3i+2:3i) |
| ch_bcd | output | 3 | Per-channel BCD flag |

## Verification
The hardest state to reach is a channel that holds a pending status and a pending count at the same moment, in several channels at once, with the live count moving underneath. The stimulus issues read-back commands with different channel masks and latch bits. Between repeated latch commands it changes the count inputs and the output levels, so that each read shows whether the frozen or the fresh value came back. Sequencer corner cases are covered by leaving a word write or a word read half done and then rewriting the control word.

// File: rtl/tmr_portfront.sv
module tmr_portfront #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [47:0]   live_cnt,
  input  logic [2:0]    ch_out,
  output logic [2:0]    load_stb,
  output logic [47:0]   load_val,
  output logic [8:0]    ch_mode,
  output logic [2:0]    ch_bcd
);
  localparam int NCH = 3;
  localparam int CW  = 16;

  wire [1:0] a      = addr[1:0];
  wire       ctl_wr = wr_en && (a == 2'd3);
  wire [1:0] sel    = wdata[7:6];
  wire       rbk    = ctl_wr && (sel == 2'd3);

  logic [7:0] rd_byte [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [1:0] IDX = 2'(i);
    logic [1:0]    acc, cst;
    logic [2:0]    mode;
    logic          bcd, wr_hi, rd_hi, spend, stb;
    logic [7:0]    wlat, sbyte, rd;
    logic [CW-1:0] clat, lval;

    wire [CW-1:0] live    = live_cnt[CW*i +: CW];
    wire          dwr     = wr_en && (a == IDX);
    wire          drd     = rd_en && !wr_en && (a == IDX);
    wire          cmd     = ctl_wr && (sel == IDX);
    wire          lat_cnt = (cmd && wdata[5:4] == 2'd0) || (rbk && wdata[i+1] && !wdata[5]);
    wire          lat_st  = rbk && wdata[i+1] && !wdata[4];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc <= 2'd1; mode <= 3'd0; bcd <= 1'b0;
        wr_hi <= 1'b0; rd_hi <= 1'b0; wlat <= 8'd0;
        clat <= '0; cst <= 2'd0; spend <= 1'b0; sbyte <= 8'd0;
        stb <= 1'b0; lval <= '0;
      end else begin
        stb <= 1'b0;
        if (cmd && wdata[5:4] != 2'd0) begin
          acc <= wdata[5:4]; mode <= wdata[3:1]; bcd <= wdata[0];
          wr_hi <= 1'b0; rd_hi <= 1'b0;
        end
        if (lat_cnt && cst == 2'd0) begin
          clat <= live; cst <= acc;
        end
        if (lat_st && !spend) begin
          spend <= 1'b1; sbyte <= {ch_out[i], 1'b0, acc, mode, bcd};
        end
        if (dwr) begin
          case (acc)
            2'd1: begin stb <= 1'b1; lval <= {8'h00, wdata}; end
            2'd2: begin stb <= 1'b1; lval <= {wdata, 8'h00}; end
            2'd3: begin
              if (!wr_hi) begin wlat <= wdata; wr_hi <= 1'b1; end
              else begin stb <= 1'b1; lval <= {wdata, wlat}; wr_hi <= 1'b0; end
            end
            default: ;
          endcase
        end
        if (drd) begin
          if (spend) spend <= 1'b0;
          else if (cst != 2'd0) cst <= (cst == 2'd3) ? 2'd2 : 2'd0;
          else if (acc == 2'd3) rd_hi <= !rd_hi;
        end
      end
    end

    always_comb begin
      if (spend) rd = sbyte;
      else if (cst != 2'd0) rd = (cst == 2'd2) ? clat[15:8] : clat[7:0];
      else case (acc)
        2'd2:    rd = live[15:8];
        2'd3:    rd = rd_hi ? live[15:8] : live[7:0];
        default: rd = live[7:0];
      endcase
    end

    assign rd_byte[i]           = rd;
    assign load_stb[i]          = stb;
    assign load_val[CW*i +: CW] = lval;
    assign ch_mode[3*i +: 3]    = mode;
    assign ch_bcd[i]            = bcd;
  end

  always_comb begin
    case (a)
      2'd0:    rdata = rd_byte[0];
      2'd1:    rdata = rd_byte[1];
      2'd2:    rdata = rd_byte[2];
      default: rdata = 8'h00;
    endcase
  end
endmodule

module tmr_portfront_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    rdata,
  input logic [2:0]    load_stb
);
  a_r1_ctl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[1:0] == 2'd3) |-> (rdata == 8'h00));

  a_r12_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));

  a_r12_ctl_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1:0] == 2'd3) |=> (load_stb == 3'b000));

  a_r12_read_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> (load_stb == 3'b000));

  for (genvar i = 0; i < 3; i++) begin : g_ld
    a_r12_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb[i] |-> $past(wr_en && addr[1:0] == 2'(i)));
  end
endmodule

bind tmr_portfront tmr_portfront_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .load_stb(load_stb)
);

// File: tb/tmr_portfront_bench.sv
module tmr_portfront_bench;
  localparam int PERIOD = 10;
  localparam int NV = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] live_cnt = {16'h5A0F, 16'hABCD, 16'h1234};
  logic [2:0]  ch_out = 3'b101;
  logic [2:0]  load_stb;
  logic [47:0] load_val;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;

  int checks = 0, fails = 0;
  bit done = 0;

  tmr_portfront u_tmr_portfront (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .ch_out(ch_out),
    .load_stb(load_stb), .load_val(load_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  always #(PERIOD/2) clk = ~clk;

  // op: 0 write, 1 read and compare, 2 load expected, 3 no load expected
  // {op, addr, data, expected, requirement}
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 2'd3, 8'h34, 16'h0000, 4'd2},  // R2 ch0 word, mode 2
    {2'd0, 2'd0, 8'h78, 16'h0000, 4'd5},  // R5
    {2'd3, 2'd0, 8'h00, 16'h0000, 4'd5},  // R5 no load after first byte
    {2'd0, 2'd0, 8'h56, 16'h0000, 4'd5},
    {2'd2, 2'd0, 8'h00, 16'h5678, 4'd5},
    {2'd0, 2'd0, 8'h11, 16'h0000, 4'd5},
    {2'd0, 2'd0, 8'h22, 16'h0000, 4'd5},
    {2'd2, 2'd0, 8'h00, 16'h2211, 4'd5},  // R5 back to low byte
    {2'd0, 2'd3, 8'h61, 16'h0000, 4'd2},  // ch1 high only, bcd
    {2'd0, 2'd1, 8'h9C, 16'h0000, 4'd6},
    {2'd2, 2'd1, 8'h00, 16'h9C00, 4'd6},  // R6
    {2'd0, 2'd3, 8'h98, 16'h0000, 4'd2},  // ch2 low only, mode 4
    {2'd0, 2'd2, 8'h3F, 16'h0000, 4'd6},
    {2'd2, 2'd2, 8'h00, 16'h003F, 4'd6},  // R6
    {2'd1, 2'd3, 8'h00, 16'h0000, 4'd1},  // R1
    {2'd1, 2'd0, 8'h00, 16'h0034, 4'd11}, // R11
    {2'd1, 2'd0, 8'h00, 16'h0012, 4'd11},
    {2'd1, 2'd1, 8'h00, 16'h00AB, 4'd11},
    {2'd1, 2'd2, 8'h00, 16'h000F, 4'd11},
    {2'd0, 2'd3, 8'hEE, 16'h0000, 4'd7},  // R7 status, all channels
    {2'd1, 2'd0, 8'h00, 16'h00B4, 4'd8},  // R8
    {2'd1, 2'd1, 8'h00, 16'h0021, 4'd8},
    {2'd1, 2'd2, 8'h00, 16'h0098, 4'd8},
    {2'd1, 2'd0, 8'h00, 16'h0034, 4'd10}, // R10 live after status
    {2'd0, 2'd3, 8'hC4, 16'h0000, 4'd7},  // R7 count+status ch1
    {2'd1, 2'd1, 8'h00, 16'h0021, 4'd10}, // R10 status first
    {2'd1, 2'd1, 8'h00, 16'h00AB, 4'd10},
    {2'd1, 2'd1, 8'h00, 16'h00AB, 4'd10},
    {2'd0, 2'd0, 8'h77, 16'h0000, 4'd4},  // R4 half word
    {2'd0, 2'd3, 8'h34, 16'h0000, 4'd4},
    {2'd0, 2'd0, 8'h01, 16'h0000, 4'd4},
    {2'd0, 2'd0, 8'h02, 16'h0000, 4'd4},
    {2'd2, 2'd0, 8'h00, 16'h0201, 4'd4},
    {2'd1, 2'd0, 8'h00, 16'h0034, 4'd4},
    {2'd0, 2'd3, 8'h40, 16'h0000, 4'd3},  // R3 latch ch1
    {2'd1, 2'd1, 8'h00, 16'h00AB, 4'd3},
    {2'd0, 2'd3, 8'hE4, 16'h0000, 4'd3},
    {2'd1, 2'd1, 8'h00, 16'h0021, 4'd3},  // settings kept
    {2'd1, 2'd0, 8'h00, 16'h0012, 4'd11},
    {2'd3, 2'd1, 8'h00, 16'h0000, 4'd12}  // R12
  };

  task automatic check(input bit ok, input int req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] o, input logic [3:0] ad, input logic [7:0] d,
                    input logic [15:0] e, input int req);
    case (o)
      2'd0: begin addr = ad; wdata = d; wr_en = 1'b1; end
      2'd1: begin addr = ad; rd_en = 1'b1; #1 check(rdata == e[7:0], req, rdata, e[7:0]); end
      2'd2: check(load_stb == (3'b001 << ad[1:0]) && load_val[16*ad[1:0] +: 16] == e,
                  req, {load_stb, load_val[16*ad[1:0] +: 16]}, {3'b001 << ad[1:0], e});
      default: check(load_stb == 3'b000, req, load_stb, 0);
    endcase
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(load_stb == 3'b000, 12, load_stb, 0);            // R12 reset
    op(2'd1, 4'd3, 8'h00, 16'h0000, 1);                     // R1
    op(2'd1, 4'd0, 8'h00, 16'h0034, 2);                     // R2 reset access
    op(2'd1, 4'd0, 8'h00, 16'h0034, 11);                    // R11 no toggle
    for (int k = 0; k < NV; k++)
      op(VEC[k][31:30], {2'b00, VEC[k][29:28]}, VEC[k][27:20], VEC[k][19:4], int'(VEC[k][3:0]));
    op(2'd0, 4'b0101, 8'h33, 16'h0000, 1);                  // R1 alias
    op(2'd2, 4'd1, 8'h00, 16'h3300, 1);
    op(2'd1, 4'b1111, 8'h00, 16'h0000, 1);
    op(2'd0, 4'd3, 8'h00, 16'h0000, 9);                     // R9 count once
    live_cnt[15:0] = 16'h4321;
    op(2'd0, 4'd3, 8'h00, 16'h0000, 9);
    op(2'd1, 4'd0, 8'h00, 16'h0034, 9);
    op(2'd1, 4'd0, 8'h00, 16'h0012, 9);
    op(2'd1, 4'd0, 8'h00, 16'h0021, 10);
    op(2'd0, 4'd3, 8'hE8, 16'h0000, 9);                     // R9 status once
    ch_out = 3'b001;
    op(2'd0, 4'd3, 8'hE8, 16'h0000, 9);
    op(2'd1, 4'd2, 8'h00, 16'h0098, 9);
    op(2'd1, 4'd2, 8'h00, 16'h000F, 10);
    op(2'd0, 4'd3, 8'hE8, 16'h0000, 8);
    op(2'd1, 4'd2, 8'h00, 16'h0018, 8);                     // R8 level low
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule